// File: doc/BRIEF.md
# Dead-Time Self-Tuning Threshold Trimmer

This block closes a slow digital loop around the turn-off point of a synchronous rectifier switch. Every switching cycle it measures, in clock cycles, how long the drain takes to climb above its high-detect level after the gate has been switched off. It then moves a small trim code by one step so that this dead time settles on a fixed target. The trim code drives an external threshold DAC that sets the turn-off comparator level; the DAC and both comparators are outside this block.

The gate state and the digitized drain-high comparator come in as clocked levels. A one-cycle cycle-valid strobe marks the point in each switching period where the last measurement may be applied to the code. A measurement whose drain-high event never arrives within a timeout window is dropped, so a missing edge can never move the threshold. The code saturates at both ends of its range and starts from mid-scale after reset.

Top module: `dtt_trim_top`

## Requirements
- R1: While reset is asserted and until the first update afterwards, `trim_code` equals 8, the mid-scale of the 4-bit range, and `dead_meas` equals 0.
- R2: If `gate_on` is sampled high at clock edge k-1 and low at edge k, and `drain_hi` is first sampled high at edge k+D (1 <= D <= TIMEOUT_CYC), then `dead_meas` equals D from the edge after k+D-1 on, and it changes at no other time.
- R3: A `cyc_valid` pulse that finds a pending measurement greater than TARGET_CYC (default 50 cycles, 200 ns at 250 MHz) raises `trim_code` by exactly one at the next edge.
- R4: A `cyc_valid` pulse that finds a pending measurement below TARGET_CYC - HYST_CYC (default 45) lowers `trim_code` by exactly one.
- R5: A pending measurement in the band from TARGET_CYC - HYST_CYC to TARGET_CYC, both ends included, leaves `trim_code` unchanged.
- R6: `trim_code` stays at 15 when asked to go up from 15 and stays at 0 when asked to go down from 0; it never wraps.
- R7: If no `drain_hi` arrives within TIMEOUT_CYC cycles after a gate fall, that cycle leaves both `trim_code` and `dead_meas` unchanged.
- R8: Each measurement is used at most once: a second `cyc_valid` pulse with no new completed measurement, or a pulse after a new gate fall whose measurement has not yet completed, leaves `trim_code` unchanged.
- R9: A `cyc_valid` pulse in the same cycle as a gate fall applies the measurement of the previous period; a pulse in the same cycle as the drain-high capture does not use that capture, which stays pending for the next pulse.
- R10: `trim_code` changes only at the edge after a `cyc_valid` pulse and by at most one step; with a plant whose dead time falls as the code rises, repeated periods drive the code to the step where the dead time enters the hold band and keep it there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gate_on | input | 1 | Gate drive state, 1 while the rectifier switch is on |
| drain_hi | input | 1 | Digitized drain-above-high-detect comparator |
| cyc_valid | input | 1 | One-cycle strobe that applies the pending measurement |
| trim_code | output | 4 | Turn-off threshold trim code, 0 to 15 |
| dead_meas | output | CNT_W (8 by default) | Last completed dead-time measurement in clock cycles |

## Verification
Two functions can meet at one clock edge: the application of the pending measurement by `cyc_valid` and the bookkeeping of a new measurement, either its start at a gate fall or its capture at the drain-high edge. The bench provokes both by raising `cyc_valid` in the very cycle the gate falls and, separately, in the very cycle `drain_hi` is first high. Its model then expects the code to follow the older measurement in the first case and to stay put in the second, with the fresh capture applied at the following strobe.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

  // Direction chosen for the trim code at a strobe.
  typedef enum logic [1:0] {
    TRIM_HOLD = 2'd0,
    TRIM_UP   = 2'd1,
    TRIM_DOWN = 2'd2
  } trim_dir_e;

endpackage

// File: rtl/dtt_gate_edge.sv
// Registers the gate level and flags its high-to-low transition.
module dtt_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic fall_o
);

  logic gate_q;
  logic gate_d;

  always_comb begin
    gate_d = gate_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
    end
  end

  assign fall_o = gate_q & ~gate_i;

endmodule

// File: rtl/dtt_interval_meas.sv
// Counts clock cycles from a gate fall to the first drain-high sample.
module dtt_interval_meas #(
  parameter int CNT_W       = 8,
  parameter int TIMEOUT_CYC = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             drain_hi_i,
  input  logic             consume_i,
  output logic             ready_o,
  output logic [CNT_W-1:0] meas_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] meas_q, meas_d;
  logic             rdy_q, rdy_d;
  logic             cnt_en, meas_en;
  logic             capture;
  logic             expire;

  always_comb begin
    capture = run_q & drain_hi_i & ~start_i;
    expire  = run_q & ~drain_hi_i & ~start_i & (cnt_q == CNT_LAST);
    cnt_en  = start_i | run_q;
    meas_en = capture;

    run_d = run_q;
    if (start_i) begin
      run_d = 1'b1;
    end else if (capture || expire) begin
      run_d = 1'b0;
    end

    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = '0;
    end else if (run_q && !capture && !expire) begin
      cnt_d = cnt_q + 1'b1;
    end

    meas_d = cnt_q + 1'b1;

    rdy_d = rdy_q;
    if (capture) begin
      rdy_d = 1'b1;
    end else if (start_i || consume_i) begin
      rdy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      run_q <= run_d;
      rdy_q <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_q <= '0;
    end else if (meas_en) begin
      meas_q <= meas_d;
    end
  end

  assign ready_o = rdy_q;
  assign meas_o  = meas_q;

  // R2
  meas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(drain_hi_i) |-> $stable(meas_o));

  // R7
  cnt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (int'(cnt_q) < TIMEOUT_CYC));

  // R2
  meas_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (int'(meas_o) >= 1 && int'(meas_o) <= TIMEOUT_CYC));

endmodule

// File: rtl/dtt_trim_step.sv
// Compares a pending measurement with the target band and steps a
// saturating trim code.
module dtt_trim_step
  import dtt_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int CNT_W      = 8,
  parameter int TARGET_CYC = 50,
  parameter int HYST_CYC   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              ready_i,
  input  logic [CNT_W-1:0]  meas_i,
  output logic [CODE_W-1:0] code_o
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1 << (CODE_W - 1));
  localparam logic [CNT_W-1:0]  HI_LIM   = CNT_W'(TARGET_CYC);
  localparam logic [CNT_W-1:0]  LO_LIM   = CNT_W'(TARGET_CYC - HYST_CYC);

  trim_dir_e         dir;
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;
  logic              apply;

  always_comb begin
    apply = strobe_i & ready_i;
    dir   = TRIM_HOLD;
    if (apply) begin
      if (meas_i > HI_LIM) begin
        dir = TRIM_UP;
      end else if (meas_i < LO_LIM) begin
        dir = TRIM_DOWN;
      end
    end

    code_d = code_q;
    unique case (dir)
      TRIM_UP:   if (code_q != CODE_MAX) code_d = code_q + 1'b1;
      TRIM_DOWN: if (code_q != '0)       code_d = code_q - 1'b1;
      default:   code_d = code_q;
    endcase
    code_en = (dir != TRIM_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_MID;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  assign code_o = code_q;

  // R10
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe_i && ready_i) |-> $stable(code_o));

  // R10
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |->
      (int'(code_o) == int'($past(code_o)) + 1 || int'(code_o) + 1 == int'($past(code_o))));

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code_o) == CODE_MAX |-> code_o != '0) and ($past(code_o) == '0 |-> code_o != CODE_MAX));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && ready_i && meas_i > HI_LIM && code_o != CODE_MAX) |=>
      int'(code_o) == int'($past(code_o)) + 1);

  // R5
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && ready_i && meas_i >= LO_LIM && meas_i <= HI_LIM) |=> $stable(code_o));

endmodule

// File: rtl/dtt_trim_top.sv
module dtt_trim_top #(
  parameter int CODE_W      = 4,
  parameter int TARGET_CYC  = 50,
  parameter int HYST_CYC    = 5,
  parameter int TIMEOUT_CYC = 250,
  localparam int CNT_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_on,
  input  logic              drain_hi,
  input  logic              cyc_valid,
  output logic [CODE_W-1:0] trim_code,
  output logic [CNT_W-1:0]  dead_meas
);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             gate_fall;
  logic             meas_ready;
  logic [CNT_W-1:0] meas_val;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  dtt_gate_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .gate_i (gate_on),
    .fall_o (gate_fall)
  );

  dtt_interval_meas #(
    .CNT_W       (CNT_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_meas (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (gate_fall),
    .drain_hi_i (drain_hi),
    .consume_i  (cyc_valid),
    .ready_o    (meas_ready),
    .meas_o     (meas_val)
  );

  dtt_trim_step #(
    .CODE_W     (CODE_W),
    .CNT_W      (CNT_W),
    .TARGET_CYC (TARGET_CYC),
    .HYST_CYC   (HYST_CYC)
  ) u_step (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe_i (cyc_valid),
    .ready_i  (meas_ready),
    .meas_i   (meas_val),
    .code_o   (trim_code)
  );

  assign dead_meas = meas_val;

  // R8
  single_use_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(cyc_valid) && !$past(drain_hi)) |-> !meas_ready);

  initial begin
    if (HYST_CYC >= TARGET_CYC || TIMEOUT_CYC <= TARGET_CYC) begin
      $display("dtt_trim_top: parameter set out of range");
    end
  end

endmodule

// File: tb/dtt_trim_top_bench.sv
module dtt_trim_top_bench;

  localparam int TGT = 50;
  localparam int HYS = 5;
  localparam int TMO = 250;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       gate_on;
  logic       drain_hi;
  logic       cyc_valid;
  logic [3:0] trim_code;
  logic [7:0] dead_meas;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int exp_code;
  int exp_meas;
  bit pend;

  always #2 clk = ~clk;

  dtt_trim_top u_dtt_trim_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_on   (gate_on),
    .drain_hi  (drain_hi),
    .cyc_valid (cyc_valid),
    .trim_code (trim_code),
    .dead_meas (dead_meas)
  );

  function automatic int nxt(int c, bit p, int m);
    if (!p) return c;
    if (m > TGT) return (c < 15) ? c + 1 : c;
    if (m < TGT - HYS) return (c > 0) ? c - 1 : c;
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // One switching period. d > TMO means the drain edge never comes.
  task automatic period(int d, bit sfall, bit scap, string req);
    @(negedge clk);
    gate_on = 1'b0;
    if (sfall) begin
      cyc_valid = 1'b1;
      exp_code = nxt(exp_code, pend, exp_meas);
    end
    pend = 0;
    @(negedge clk);
    cyc_valid = 1'b0;
    if (sfall) chk(int'(trim_code) == exp_code, "R9 strobe at fall", int'(trim_code), exp_code);
    if (d <= TMO) begin
      repeat (d - 1) @(negedge clk);
      drain_hi = 1'b1;
      if (scap) begin
        cyc_valid = 1'b1;
        exp_code = nxt(exp_code, pend, exp_meas);
      end
      @(negedge clk);
      drain_hi = 1'b0;
      cyc_valid = 1'b0;
      exp_meas = d;
      pend = 1;
      chk(int'(dead_meas) == exp_meas, req, int'(dead_meas), exp_meas);
      if (scap) chk(int'(trim_code) == exp_code, "R9 strobe at capture", int'(trim_code), exp_code);
    end else begin
      repeat (TMO + 8) @(negedge clk);
      chk(int'(dead_meas) == exp_meas, "R7 meas kept", int'(dead_meas), exp_meas);
    end
    gate_on = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe(string req);
    @(negedge clk);
    cyc_valid = 1'b1;
    exp_code = nxt(exp_code, pend, exp_meas);
    pend = 0;
    @(negedge clk);
    cyc_valid = 1'b0;
    chk(int'(trim_code) == exp_code, req, int'(trim_code), exp_code);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    void'($urandom(32'd20245));
    rst_n = 1'b0; gate_on = 1'b1; drain_hi = 1'b0; cyc_valid = 1'b0;
    exp_code = 8; exp_meas = 0; pend = 0;
    repeat (4) @(negedge clk);
    chk(trim_code == 4'd8, "R1 code in reset", int'(trim_code), 8);
    chk(dead_meas == 8'd0, "R1 meas in reset", int'(dead_meas), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(trim_code == 4'd8, "R1 code after reset", int'(trim_code), 8);

    // R3 R4 R5 around the band edges
    period(51, 0, 0, "R2 meas 51"); strobe("R3 above target");
    period(50, 0, 0, "R2 meas 50"); strobe("R5 at target");
    period(45, 0, 0, "R2 meas 45"); strobe("R5 at low edge");
    period(44, 0, 0, "R2 meas 44"); strobe("R4 below band");
    period(1, 0, 0, "R2 meas 1");   strobe("R4 short");
    period(TMO, 0, 0, "R2 meas max"); strobe("R3 longest");

    // R8 double strobe, and strobe before completion
    strobe("R8 second strobe");
    period(TMO + 20, 0, 0, "R7"); strobe("R7 timeout hold");

    // R9 coincident strobes
    period(80, 0, 0, "R2 meas 80");
    period(20, 1, 0, "R2 meas 20");
    period(70, 0, 1, "R2 meas 70");
    strobe("R9 pending after capture");

    // R6 saturation high then low
    for (int i = 0; i < 10; i++) begin
      period(100, 0, 0, "R2 sat up"); strobe("R6 up");
    end
    chk(trim_code == 4'd15, "R6 top", int'(trim_code), 15);
    for (int i = 0; i < 18; i++) begin
      period(10, 0, 0, "R2 sat down"); strobe("R6 down");
    end
    chk(trim_code == 4'd0, "R6 bottom", int'(trim_code), 0);

    // R10 convergence with a plant: dead time 90 - 4*code
    for (int i = 0; i < 16; i++) begin
      period(90 - 4 * exp_code, 0, 0, "R2 plant"); strobe("R10 plant step");
    end
    chk(trim_code == 4'd10, "R10 converged", int'(trim_code), 10);
    c0 = exp_code;
    for (int i = 0; i < 4; i++) begin
      period(90 - 4 * exp_code, 0, 0, "R2 plant hold"); strobe("R10 plant hold");
    end
    chk(int'(trim_code) == c0, "R10 holds", int'(trim_code), c0);

    // Random mix
    for (int i = 0; i < 120; i++) begin
      int d;
      int r;
      r = int'($urandom_range(0, 9));
      d = (r == 0) ? TMO + 10 : int'($urandom_range(2, TMO));
      period(d, (r == 1), (r == 2) && (d <= TMO), "R2 random");
      if (r != 3) strobe("R10 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule